// File: doc/BRIEF.md
# UART Interrupt Identification and Clearing Controller

This block is the interrupt identification logic of a single-channel UART with receive and transmit FIFOs. It takes event pulses from the receiver, the transmitter, the modem-status logic and the flow-control logic, together with the receive FIFO fill level and its trigger threshold. It also takes one-cycle strobes for accesses to the line status, modem status, interrupt status and receive holding registers, and for writes to the transmit holding register. It keeps one pending flag per interrupt source, and each flag is cleared by its own register access.

The highest-priority source that is both pending and enabled is resolved into an 8-bit interrupt status value. A separate copy of that value is captured when the status register is read, so a clear caused by the same read does not change the value returned. The interrupt output is high whenever any enabled source is pending. The two flow-control sources, character match and CTS/RTS rise, are reported only while the enhanced-feature enable is set.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset no flag is pending, `irq` is 0, `isr_rdata` is 0x01, and `isr_now` is 0x01 with bits 7:6 set as described in R3.
- R2: Source indices and codes in `isr_now[5:0]` are: 0 line status 0x06, 1 receive time-out 0x0C, 2 data ready 0x04, 3 transmit ready 0x02, 4 modem status 0x00, 5 character match 0x10, 6 CTS/RTS rise 0x20, 7 wakeup 0x01. When nothing is pending the code is 0x01. The lowest index that is pending and enabled wins.
- R3: `isr_now[7:6]` reads 2'b11 while `fifo_en` is 1 and 2'b00 while it is 0.
- R4: A source whose `src_en` bit (same index as in R2) is 0 is neither reported nor drives `irq`. `irq` is the OR of all enabled pending sources. Whenever `isr_now[0]` is 0, `irq` is 1.
- R5: While `enh_en` is 0, sources 5 and 6 are neither reported nor drive `irq`.
- R6: The line-status flag is set by `line_err_ev` and cleared by `lsr_rd`.
- R7: The modem-status flag (`modem_ev`) and the CTS/RTS flag (`flow_rise_ev`) are both cleared by `msr_rd`.
- R8: Data ready is pending, one cycle after the level is sampled, exactly while `rx_level >= rx_trig`. No register access clears it.
- R9: The time-out flag is set by `rx_tmo_ev` and cleared by `rhr_rd`.
- R10: The transmit-ready flag is set by `tx_ready_ev` and cleared by `isr_rd` or `thr_wr`.
- R11: The Xon/Xoff match (`xon_xoff_ev`) and wakeup (`wake_ev`) flags clear on `isr_rd`. The special-character flag (`spc_char_ev`) clears on `isr_rd` or `rx_char_ev`. Either match flag makes source 5 pending.
- R12: When a source's set event and its clearing access occur in the same cycle, the flag ends up set.
- R13: On a cycle with `isr_rd` high, `isr_rdata` takes that cycle's `isr_now` at the clock edge and holds it until the next `isr_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | FIFOs enabled, reported in bits 7:6 |
| enh_en | input | 1 | Enhanced-feature enable for sources 5 and 6 |
| src_en | input | 8 | Per-source interrupt enables, indexed as in R2 |
| line_err_ev | input | 1 | Receiver line error event |
| rx_tmo_ev | input | 1 | Receive character time-out event |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive trigger level |
| tx_ready_ev | input | 1 | Transmit holding space available event |
| modem_ev | input | 1 | Modem input change event |
| xon_xoff_ev | input | 1 | Received Xon or Xoff match event |
| spc_char_ev | input | 1 | Received special-character match event |
| rx_char_ev | input | 1 | A character was received |
| flow_rise_ev | input | 1 | CTS# or RTS# low-to-high event |
| wake_ev | input | 1 | Wakeup event |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| isr_rd | input | 1 | Interrupt status register read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| isr_now | output | 8 | Live interrupt status value |
| isr_rdata | output | 8 | Status value captured by the last status read |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 64-entry FIFO depth, which gives a 7-bit level, and uses a trigger level of 16. With eight sources, every combination of pending sources can be swept under both FIFO settings, and every enable mask can be swept with the enhanced gate on and off. The small source count also lets every pairing of a source with each register access or received character be tried, so each clearing rule is confirmed and each non-clearing access is shown to leave the flag pending. The data-ready threshold is tested one below the trigger and exactly at it.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC  = 8;
  localparam int NFLAG = NSRC + 1;

  localparam int SRC_LS  = 0;
  localparam int SRC_TO  = 1;
  localparam int SRC_RD  = 2;
  localparam int SRC_TX  = 3;
  localparam int SRC_MS  = 4;
  localparam int SRC_XC  = 5;
  localparam int SRC_FC  = 6;
  localparam int SRC_WK  = 7;
  localparam int FLG_SPC = 8;

  // Status bits 5:0 for a given source index (bit 0 is the active-low pending bit)
  function automatic logic [5:0] src_code(input int idx);
    case (idx)
      SRC_LS:  return 6'h06;
      SRC_TO:  return 6'h0C;
      SRC_RD:  return 6'h04;
      SRC_TX:  return 6'h02;
      SRC_MS:  return 6'h00;
      SRC_XC:  return 6'h10;
      SRC_FC:  return 6'h20;
      default: return 6'h01;
    endcase
  endfunction

  // Enable mask after the enhanced-feature gate
  function automatic logic [NSRC-1:0] gate_mask(input logic [NSRC-1:0] en, input logic enh);
    logic [NSRC-1:0] m;
    m = en;
    if (!enh) begin
      m[SRC_XC] = 1'b0;
      m[SRC_FC] = 1'b0;
    end
    return m;
  endfunction
endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/uirq_events.sv
module uirq_events
  import uirq_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             line_err_ev,
  input  logic             rx_tmo_ev,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             tx_ready_ev,
  input  logic             modem_ev,
  input  logic             xon_xoff_ev,
  input  logic             spc_char_ev,
  input  logic             rx_char_ev,
  input  logic             flow_rise_ev,
  input  logic             wake_ev,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             isr_rd,
  input  logic             rhr_rd,
  input  logic             thr_wr,
  output logic [NFLAG-1:0] set_v,
  output logic [NFLAG-1:0] clr_v
);
  logic at_trig;
  assign at_trig = (rx_level >= rx_trig);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[SRC_LS]  = line_err_ev;   clr_v[SRC_LS]  = lsr_rd;
    set_v[SRC_TO]  = rx_tmo_ev;     clr_v[SRC_TO]  = rhr_rd;
    set_v[SRC_RD]  = at_trig;       clr_v[SRC_RD]  = !at_trig;
    set_v[SRC_TX]  = tx_ready_ev;   clr_v[SRC_TX]  = isr_rd | thr_wr;
    set_v[SRC_MS]  = modem_ev;      clr_v[SRC_MS]  = msr_rd;
    set_v[SRC_XC]  = xon_xoff_ev;   clr_v[SRC_XC]  = isr_rd;
    set_v[SRC_FC]  = flow_rise_ev;  clr_v[SRC_FC]  = msr_rd;
    set_v[SRC_WK]  = wake_ev;       clr_v[SRC_WK]  = isr_rd;
    set_v[FLG_SPC] = spc_char_ev;   clr_v[FLG_SPC] = isr_rd | rx_char_ev;
  end
endmodule

// File: rtl/uirq_resolve.sv
module uirq_resolve
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0] pend_en,
  input  logic            fifo_en,
  output logic [7:0]      status,
  output logic            any
);
  logic [5:0] code;

  always_comb begin
    code = 6'h01;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_en[i]) code = src_code(i);
    end
  end

  assign any    = |pend_en;
  assign status = {fifo_en, fifo_en, code};
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             enh_en,
  input  logic [7:0]       src_en,
  input  logic             line_err_ev,
  input  logic             rx_tmo_ev,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             tx_ready_ev,
  input  logic             modem_ev,
  input  logic             xon_xoff_ev,
  input  logic             spc_char_ev,
  input  logic             rx_char_ev,
  input  logic             flow_rise_ev,
  input  logic             wake_ev,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             isr_rd,
  input  logic             rhr_rd,
  input  logic             thr_wr,
  output logic [7:0]       isr_now,
  output logic [7:0]       isr_rdata,
  output logic             irq
);
  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;
  logic [NFLAG-1:0] flag;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  pend_en;
  logic             any_en;

  uirq_events #(.LVL_W(LVL_W)) u_ev (
    .line_err_ev (line_err_ev),
    .rx_tmo_ev   (rx_tmo_ev),
    .rx_level    (rx_level),
    .rx_trig     (rx_trig),
    .tx_ready_ev (tx_ready_ev),
    .modem_ev    (modem_ev),
    .xon_xoff_ev (xon_xoff_ev),
    .spc_char_ev (spc_char_ev),
    .rx_char_ev  (rx_char_ev),
    .flow_rise_ev(flow_rise_ev),
    .wake_ev     (wake_ev),
    .lsr_rd      (lsr_rd),
    .msr_rd      (msr_rd),
    .isr_rd      (isr_rd),
    .rhr_rd      (rhr_rd),
    .thr_wr      (thr_wr),
    .set_v       (set_v),
    .clr_v       (clr_v)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    uirq_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_v[g]),
      .clr_i(clr_v[g]),
      .q_o  (flag[g])
    );
  end

  // Source 5 is pending for either match flag
  always_comb begin
    pend         = flag[NSRC-1:0];
    pend[SRC_XC] = flag[SRC_XC] | flag[FLG_SPC];
  end

  assign pend_en = pend & gate_mask(src_en, enh_en);

  uirq_resolve u_res (
    .pend_en(pend_en),
    .fifo_en(fifo_en),
    .status (isr_now),
    .any    (any_en)
  );

  assign irq = any_en;

  // Status value captured in the read cycle, before that read's clears land
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_rdata <= 8'h01;
    else if (isr_rd) isr_rdata <= isr_now;
  end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enh_en,
  input logic       line_err_ev,
  input logic       tx_ready_ev,
  input logic       lsr_rd,
  input logic       isr_rd,
  input logic       thr_wr,
  input logic [7:0] pend,
  input logic [7:0] isr_now,
  input logic [7:0] isr_rdata,
  input logic       irq
);
  assert_lsr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !line_err_ev) |=> !pend[0]);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    line_err_ev |=> pend[0]);

  assert_tx_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_rd || thr_wr) && !tx_ready_ev) |=> !pend[3]);

  assert_read_latch_R13: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd |=> (isr_rdata == $past(isr_now)));

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> isr_now[0]);

  assert_pending_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_now[0] |-> irq);

  assert_enh_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |-> (isr_now[5:4] == 2'b00));
endmodule

bind uart_irq_ident uirq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enh_en     (enh_en),
  .line_err_ev(line_err_ev),
  .tx_ready_ev(tx_ready_ev),
  .lsr_rd     (lsr_rd),
  .isr_rd     (isr_rd),
  .thr_wr     (thr_wr),
  .pend       (pend),
  .isr_now    (isr_now),
  .isr_rdata  (isr_rdata),
  .irq        (irq)
);

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/1ps
module sim_uart_irq_ident;
  localparam int LW   = 7;
  localparam logic [LW-1:0] TRIG = 7'd16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b1, enh_en = 1'b1;
  logic [7:0] src_en = 8'hFF;
  logic line_err_ev = 0, rx_tmo_ev = 0, tx_ready_ev = 0, modem_ev = 0;
  logic xon_xoff_ev = 0, spc_char_ev = 0, rx_char_ev = 0, flow_rise_ev = 0, wake_ev = 0;
  logic lsr_rd = 0, msr_rd = 0, isr_rd = 0, rhr_rd = 0, thr_wr = 0;
  logic [LW-1:0] rx_level = '0;
  logic [LW-1:0] rx_trig = TRIG;
  logic [7:0] isr_now, isr_rdata;
  logic irq;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident u0 (.*);

  function automatic logic [7:0] want_isr(input logic [7:0] pe, input logic fe);
    logic [5:0] c;
    if      (pe[0]) c = 6'h06;
    else if (pe[1]) c = 6'h0C;
    else if (pe[2]) c = 6'h04;
    else if (pe[3]) c = 6'h02;
    else if (pe[4]) c = 6'h00;
    else if (pe[5]) c = 6'h10;
    else if (pe[6]) c = 6'h20;
    else            c = 6'h01;
    return {fe, fe, c};
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // flag bits: 0..7 sources (5 = xon/xoff), 8 = special character
  task automatic raise(input logic [8:0] m);
    @(negedge clk);
    line_err_ev = m[0]; rx_tmo_ev = m[1]; rx_level = m[2] ? TRIG : '0;
    tx_ready_ev = m[3]; modem_ev = m[4]; xon_xoff_ev = m[5];
    flow_rise_ev = m[6]; wake_ev = m[7]; spc_char_ev = m[8];
    @(negedge clk);
    line_err_ev = 0; rx_tmo_ev = 0; tx_ready_ev = 0; modem_ev = 0;
    xon_xoff_ev = 0; flow_rise_ev = 0; wake_ev = 0; spc_char_ev = 0;
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk);
    lsr_rd = 1; msr_rd = 1; isr_rd = 1; rhr_rd = 1; rx_level = '0;
    @(negedge clk);
    lsr_rd = 0; msr_rd = 0; isr_rd = 0; rhr_rd = 0;
    #1;
  endtask

  task automatic access(input int a);
    @(negedge clk);
    case (a)
      0: lsr_rd = 1;
      1: msr_rd = 1;
      2: isr_rd = 1;
      3: rhr_rd = 1;
      4: thr_wr = 1;
      default: rx_char_ev = 1;
    endcase
    @(negedge clk);
    lsr_rd = 0; msr_rd = 0; isr_rd = 0; rhr_rd = 0; thr_wr = 0; rx_char_ev = 0;
    #1;
  endtask

  function automatic bit clears(input int s, input int a);
    case (s)
      0: return a == 0;
      1: return a == 3;
      2: return 1'b0;
      3: return a == 2 || a == 4;
      4, 6: return a == 1;
      5, 7: return a == 2;
      default: return a == 2 || a == 5;
    endcase
  endfunction

  function automatic string tag_of(input int s);
    case (s)
      0: return "R6";
      1: return "R9";
      2: return "R8";
      3: return "R10";
      4, 6: return "R7";
      default: return "R11";
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset isr_now", isr_now, 8'hC1);
    chk("R1 reset isr_rdata", isr_rdata, 8'h01);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    @(negedge clk); rst_n = 1;
    #1;
    chk("R1 after release", isr_now, 8'hC1);

    // R2 R3: every pending combination under both FIFO settings
    for (int fe = 0; fe < 2; fe++) begin
      fifo_en = fe[0];
      for (int m = 0; m < 256; m++) begin
        clear_all();
        raise({1'b0, m[7:0]});
        chk("R2 R3 priority sweep", isr_now, want_isr(m[7:0], fe[0]));
        chk("R4 irq sweep", {7'd0, irq}, {7'd0, m[7:0] != 0});
      end
    end

    // R4 R5: every enable mask with all sources pending
    fifo_en = 1;
    clear_all();
    raise(9'h1FF);
    for (int en = 0; en < 2; en++) begin
      for (int e = 0; e < 256; e++) begin
        logic [7:0] eff;
        @(negedge clk);
        enh_en = en[0]; src_en = e[7:0];
        #1;
        eff = e[7:0] & (en[0] ? 8'hFF : 8'h9F);
        chk("R4 R5 enable sweep", isr_now, want_isr(eff, 1'b1));
        chk("R4 R5 enable irq", {7'd0, irq}, {7'd0, eff != 0});
      end
    end
    enh_en = 1;

    // R6 R7 R9 R10 R11: each source against each access
    for (int s = 0; s < 9; s++) begin
      for (int a = 0; a < 6; a++) begin
        bit gone;
        clear_all();
        src_en = 8'h01 << ((s == 8) ? 5 : s);
        raise(9'h001 << s);
        access(a);
        gone = clears(s, a);
        chk(tag_of(s), {7'd0, irq}, {7'd0, !gone});
      end
    end

    // R8 threshold boundary
    clear_all();
    src_en = 8'h04;
    @(negedge clk); rx_level = TRIG - 1;
    @(negedge clk); #1;
    chk("R8 below trigger", {7'd0, irq}, 8'h00);
    @(negedge clk); rx_level = TRIG;
    @(negedge clk); #1;
    chk("R8 at trigger", isr_now, 8'hC4);
    @(negedge clk); rx_level = TRIG - 1;
    @(negedge clk); #1;
    chk("R8 drop below", isr_now, 8'hC1);

    // R12 set beats clear
    clear_all();
    src_en = 8'hFF;
    @(negedge clk); line_err_ev = 1; lsr_rd = 1;
    @(negedge clk); line_err_ev = 0; lsr_rd = 0; #1;
    chk("R12 line set vs read", isr_now, 8'hC6);
    clear_all();
    @(negedge clk); tx_ready_ev = 1; thr_wr = 1;
    @(negedge clk); tx_ready_ev = 0; thr_wr = 0; #1;
    chk("R12 tx set vs write", isr_now, 8'hC2);

    // R13 read capture, then hold
    clear_all();
    src_en = 8'h08;
    raise(9'h008);
    chk("R13 before read", isr_now, 8'hC2);
    @(negedge clk); isr_rd = 1;
    @(negedge clk); isr_rd = 0; #1;
    chk("R13 captured", isr_rdata, 8'hC2);
    chk("R10 cleared by read", isr_now, 8'hC1);
    @(negedge clk); #1;
    chk("R13 held", isr_rdata, 8'hC2);

    // R2 wakeup drives irq with code 0x01
    clear_all();
    src_en = 8'h80;
    raise(9'h080);
    chk("R2 wakeup code", isr_now, 8'hC1);
    chk("R2 wakeup irq", {7'd0, irq}, 8'h01);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule